// File: doc/BRIEF.md
# Half-Duplex Parallel DMA Register Interface

This block is the slave register file and the address/count engine of a half-duplex, 16-bit parallel DMA port sitting on a word-oriented system bus with 22-bit memory addresses. Software sees it as four consecutive word locations above a configurable base: a word counter, a shared address location, a control/status word and a shared data-buffer location. A concealed one-shot steering flag decides whether the shared address location reaches the low 16 address bits or the 6-bit high-address register.

After software loads a negative word count and a start address and sets the start bit, the attached user device asks for words one at a time. For each word it names the memory cycle: read memory, write memory, or read-modify-write. The block presents one request per word. When memory acknowledges, it steps the 22-bit address by two and the count by one. It stops when the count wraps to zero or when memory reports a bus fault.

Top module: `pdma_regif`

## Requirements
- R1: Accesses with `acc_sel` high reach the block only when the byte address matches the base in all bits above bit 2 and bit 0 is zero. Offsets are +0 count, +2 shared address, +4 control/status, +6 buffers. Other addresses read zero and change no state.
- R2: When the steering flag is clear, an access to offset +2 reaches the 16-bit address register and sets the flag. When the flag is set, the next access at +2 reaches the high-address register instead and clears the flag. That register stores write bits 5:0 and reads bits 15:6 as zero.
- R3: An access to offset +0, +4 or +6 clears the steering flag, so a later access at +2 reaches the 16-bit address register.
- R4: A read at offset +6 returns the input buffer, which the device loads with `dev_in_load`/`dev_in_data`. A write at +6 loads the output buffer, driven on `dev_out_data`. The two never affect each other.
- R5: Control/status bit fields: bit 0 is start (write-only, reads 0), bit 6 is interrupt enable (read/write), bit 7 is ready (read-only) and bit 15 is bus error (read-only). `irq` equals enable AND ready.
- R6: Writing start while ready clears ready and error. A request (`dma_req`) is raised only after `dev_req` is seen. It stays up with a stable address until `dma_ack` or `dma_err`. `dma_cycle` carries the device's code: 00 read memory, 01 write memory, 10 read-modify-write.
- R7: Each acknowledged word adds 2 to the 22-bit address, carrying from bit 15 into the high-address register, and adds 1 to the count.
- R8: When the acknowledged word takes the count from all-ones to zero, ready is set and no further requests are raised while ready.
- R9: A bus fault sets error and ready and ends the transfer. The address and count still point at the failing word.
- R10: While a transfer is active, writes of start, count, address and high address have no effect.
- R11: For read and read-modify-write cycles, the acknowledged memory data loads the output buffer. Write data to memory is always the input buffer.
- R12: After reset, ready is 1 and every other register, the flag and the outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_sel | input | 1 | Register access strobe, one cycle per access |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_addr | input | ADDR_W | Byte address of the access |
| acc_wdata | input | 16 | Write data |
| acc_rdata | output | 16 | Read data, valid in the access cycle |
| dev_req | input | 1 | Device asks for the next word |
| dev_cycle | input | 2 | Cycle type for the requested word |
| dev_in_load | input | 1 | Device loads the input buffer |
| dev_in_data | input | 16 | Data for the input buffer |
| dev_out_data | output | 16 | Output buffer contents |
| dma_req | output | 1 | Memory cycle request |
| dma_cycle | output | 2 | Memory cycle type |
| dma_addr | output | 22 | Memory byte address |
| dma_wdata | output | 16 | Memory write data |
| dma_rdata | input | 16 | Memory read data, valid with acknowledge |
| dma_ack | input | 1 | Memory cycle completed |
| dma_err | input | 1 | Memory cycle faulted |
| irq | output | 1 | Interrupt level |

## Verification
The engine is driven with a three-word read run that starts just below a 64 KiB boundary, so a lost carry into the high-address register shows up at the third address. A two-word write run and a single read-modify-write word separate the three cycle codes and check which buffer feeds or receives the data. A faulting second word tells an engine that rolls back or advances on error from one that holds its pointers, and a restart afterwards shows that the error clears. Alternating access orders at the shared location tell a flag that is held, cleared or ignored apart from the correct one.

// File: rtl/pdma_pkg.sv
package pdma_pkg;

  typedef enum logic [1:0] {
    CYC_RD  = 2'b00,
    CYC_WR  = 2'b01,
    CYC_RMW = 2'b10
  } cyc_e;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_WC,
    SEL_BAR,
    SEL_BAE,
    SEL_CSR,
    SEL_BUF
  } regsel_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WAIT,
    ST_BUS
  } eng_st_e;

  localparam int CSR_GO_BIT  = 0;
  localparam int CSR_IE_BIT  = 6;
  localparam int CSR_RDY_BIT = 7;
  localparam int CSR_ERR_BIT = 15;

endpackage

// File: rtl/pdma_decode.sv
module pdma_decode
  import pdma_pkg::*;
#(
  parameter int              ADDR_W = 13,
  parameter logic [ADDR_W-1:0] BASE = 13'h1F08
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_sel,
  input  logic [ADDR_W-1:0] acc_addr,
  output regsel_e           sel_o,
  output logic              redir_o
);

  logic       hit;
  logic [1:0] offset;
  logic       redir_q;
  logic       redir_d;

  assign hit    = acc_sel && (acc_addr[ADDR_W-1:3] == BASE[ADDR_W-1:3]) && !acc_addr[0];
  assign offset = acc_addr[2:1];

  always_comb begin
    sel_o = SEL_NONE;
    if (hit) begin
      case (offset)
        2'd0:    sel_o = SEL_WC;
        2'd1:    sel_o = redir_q ? SEL_BAE : SEL_BAR;
        2'd2:    sel_o = SEL_CSR;
        default: sel_o = SEL_BUF;
      endcase
    end
  end

  always_comb begin
    redir_d = redir_q;
    if (hit) begin
      redir_d = (offset == 2'd1) ? !redir_q : 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) redir_q <= 1'b0;
    else        redir_q <= redir_d;
  end

  assign redir_o = redir_q;

endmodule

// File: rtl/pdma_engine.sv
module pdma_engine
  import pdma_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int DMA_AW = 22
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_wc,
  input  logic                     wr_bar,
  input  logic                     wr_bae,
  input  logic                     wr_go,
  input  logic [WORD_W-1:0]        wdata,
  input  logic                     dev_req,
  input  logic [1:0]               dev_cycle,
  input  logic                     dma_ack,
  input  logic                     dma_err,
  output logic [WORD_W-1:0]        wc_o,
  output logic [WORD_W-1:0]        bar_o,
  output logic [DMA_AW-WORD_W-1:0] bae_o,
  output logic                     ready_o,
  output logic                     err_o,
  output logic                     dma_req_o,
  output cyc_e                     dma_cycle_o,
  output logic                     rd_load_o
);

  localparam int EXT_W = DMA_AW - WORD_W;

  eng_st_e            st_q, st_d;
  logic [WORD_W-1:0]  wc_q, wc_d;
  logic [WORD_W-1:0]  bar_q, bar_d;
  logic [EXT_W-1:0]   bae_q, bae_d;
  logic               err_q, err_d;
  cyc_e               cyc_q, cyc_d;
  logic [DMA_AW-1:0]  addr_inc;
  logic               last_word;

  assign addr_inc  = {bae_q, bar_q} + DMA_AW'(2);
  assign last_word = (wc_q == '1);

  always_comb begin
    st_d      = st_q;
    wc_d      = wc_q;
    bar_d     = bar_q;
    bae_d     = bae_q;
    err_d     = err_q;
    cyc_d     = cyc_q;
    rd_load_o = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (wr_wc)  wc_d  = wdata;
        if (wr_bar) bar_d = wdata;
        if (wr_bae) bae_d = wdata[EXT_W-1:0];
        if (wr_go) begin
          err_d = 1'b0;
          st_d  = ST_WAIT;
        end
      end
      ST_WAIT: begin
        if (dev_req) begin
          cyc_d = cyc_e'(dev_cycle);
          st_d  = ST_BUS;
        end
      end
      ST_BUS: begin
        if (dma_err) begin
          err_d = 1'b1;
          st_d  = ST_IDLE;
        end else if (dma_ack) begin
          {bae_d, bar_d} = addr_inc;
          wc_d           = wc_q + WORD_W'(1);
          rd_load_o      = (cyc_q != CYC_WR);
          st_d           = last_word ? ST_IDLE : ST_WAIT;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      wc_q  <= '0;
      bar_q <= '0;
      bae_q <= '0;
      err_q <= 1'b0;
      cyc_q <= CYC_RD;
    end else begin
      st_q  <= st_d;
      wc_q  <= wc_d;
      bar_q <= bar_d;
      bae_q <= bae_d;
      err_q <= err_d;
      cyc_q <= cyc_d;
    end
  end

  assign wc_o        = wc_q;
  assign bar_o       = bar_q;
  assign bae_o       = bae_q;
  assign err_o       = err_q;
  assign ready_o     = (st_q == ST_IDLE);
  assign dma_req_o   = (st_q == ST_BUS);
  assign dma_cycle_o = cyc_q;

endmodule

// File: rtl/pdma_regif.sv
module pdma_regif
  import pdma_pkg::*;
#(
  parameter int                ADDR_W = 13,
  parameter logic [ADDR_W-1:0] BASE   = 13'h1F08,
  parameter int                WORD_W = 16,
  parameter int                DMA_AW = 22
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_sel,
  input  logic              acc_wr,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [WORD_W-1:0] acc_wdata,
  output logic [WORD_W-1:0] acc_rdata,
  input  logic              dev_req,
  input  logic [1:0]        dev_cycle,
  input  logic              dev_in_load,
  input  logic [WORD_W-1:0] dev_in_data,
  output logic [WORD_W-1:0] dev_out_data,
  output logic              dma_req,
  output logic [1:0]        dma_cycle,
  output logic [DMA_AW-1:0] dma_addr,
  output logic [WORD_W-1:0] dma_wdata,
  input  logic [WORD_W-1:0] dma_rdata,
  input  logic              dma_ack,
  input  logic              dma_err,
  output logic              irq
);

  localparam int EXT_W = DMA_AW - WORD_W;

  logic [1:0]        rst_pipe_q;
  logic              rst_sync_n;
  regsel_e           reg_sel;
  logic              redir_q;
  logic              wr_wc, wr_bar, wr_bae, wr_csr, wr_buf, wr_go;
  logic [WORD_W-1:0] wc_q, bar_q;
  logic [EXT_W-1:0]  bae_q;
  logic              eng_ready, eng_err, rd_load;
  cyc_e              eng_cycle;
  logic              ie_q, ie_d;
  logic [WORD_W-1:0] inbuf_q, inbuf_d;
  logic [WORD_W-1:0] outbuf_q, outbuf_d;
  logic [WORD_W-1:0] csr_val;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  pdma_decode #(.ADDR_W(ADDR_W), .BASE(BASE)) decode_i (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .acc_sel  (acc_sel),
    .acc_addr (acc_addr),
    .sel_o    (reg_sel),
    .redir_o  (redir_q)
  );

  assign wr_wc  = acc_wr && (reg_sel == SEL_WC);
  assign wr_bar = acc_wr && (reg_sel == SEL_BAR);
  assign wr_bae = acc_wr && (reg_sel == SEL_BAE);
  assign wr_csr = acc_wr && (reg_sel == SEL_CSR);
  assign wr_buf = acc_wr && (reg_sel == SEL_BUF);
  assign wr_go  = wr_csr && acc_wdata[CSR_GO_BIT];

  pdma_engine #(.WORD_W(WORD_W), .DMA_AW(DMA_AW)) engine_i (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .wr_wc       (wr_wc),
    .wr_bar      (wr_bar),
    .wr_bae      (wr_bae),
    .wr_go       (wr_go),
    .wdata       (acc_wdata),
    .dev_req     (dev_req),
    .dev_cycle   (dev_cycle),
    .dma_ack     (dma_ack),
    .dma_err     (dma_err),
    .wc_o        (wc_q),
    .bar_o       (bar_q),
    .bae_o       (bae_q),
    .ready_o     (eng_ready),
    .err_o       (eng_err),
    .dma_req_o   (dma_req),
    .dma_cycle_o (eng_cycle),
    .rd_load_o   (rd_load)
  );

  always_comb begin
    ie_d     = wr_csr ? acc_wdata[CSR_IE_BIT] : ie_q;
    inbuf_d  = dev_in_load ? dev_in_data : inbuf_q;
    outbuf_d = outbuf_q;
    if (rd_load)     outbuf_d = dma_rdata;
    else if (wr_buf) outbuf_d = acc_wdata;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      ie_q     <= 1'b0;
      inbuf_q  <= '0;
      outbuf_q <= '0;
    end else begin
      ie_q     <= ie_d;
      inbuf_q  <= inbuf_d;
      outbuf_q <= outbuf_d;
    end
  end

  always_comb begin
    csr_val              = '0;
    csr_val[CSR_IE_BIT]  = ie_q;
    csr_val[CSR_RDY_BIT] = eng_ready;
    csr_val[CSR_ERR_BIT] = eng_err;
  end

  always_comb begin
    case (reg_sel)
      SEL_WC:  acc_rdata = wc_q;
      SEL_BAR: acc_rdata = bar_q;
      SEL_BAE: acc_rdata = {{(WORD_W-EXT_W){1'b0}}, bae_q};
      SEL_CSR: acc_rdata = csr_val;
      SEL_BUF: acc_rdata = inbuf_q;
      default: acc_rdata = '0;
    endcase
  end

  assign dev_out_data = outbuf_q;
  assign dma_addr     = {bae_q, bar_q};
  assign dma_wdata    = inbuf_q;
  assign dma_cycle    = eng_cycle;
  assign irq          = ie_q && eng_ready;

endmodule

// File: rtl/pdma_regif_chk.sv
module pdma_regif_chk
  import pdma_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int DMA_AW = 22
) (
  input logic              clk,
  input logic              rst_n,
  input regsel_e           sel,
  input logic              redir,
  input logic              ready,
  input logic [WORD_W-1:0] wc,
  input logic              dma_req,
  input logic              dma_ack,
  input logic              dma_err,
  input logic [DMA_AW-1:0] dma_addr
);

  p_redirect_arm_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == SEL_BAR) |=> redir);

  p_redirect_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == SEL_WC || sel == SEL_CSR || sel == SEL_BUF || sel == SEL_BAE) |=> !redir);

  p_req_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_req && !dma_ack && !dma_err) |=> (dma_req && $stable(dma_addr)));

  p_addr_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_req && dma_ack && !dma_err) |=> (dma_addr == $past(dma_addr) + DMA_AW'(2)));

  p_stop_at_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_req && dma_ack && !dma_err && wc == '1) |=> (ready && wc == '0));

  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> !dma_req);

  p_fault_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_req && dma_err) |=> (ready && !dma_req && $stable(dma_addr) && $stable(wc)));

endmodule

bind pdma_regif pdma_regif_chk #(.WORD_W(WORD_W), .DMA_AW(DMA_AW)) chk_i (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .sel      (reg_sel),
  .redir    (redir_q),
  .ready    (eng_ready),
  .wc       (wc_q),
  .dma_req  (dma_req),
  .dma_ack  (dma_ack),
  .dma_err  (dma_err),
  .dma_addr (dma_addr)
);

// File: tb/pdma_regif_tb.sv
`timescale 1ns/1ps
module pdma_regif_tb_top;

  localparam logic [12:0] BASE = 13'h1F08;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_sel = 1'b0, acc_wr = 1'b0;
  logic [12:0] acc_addr = '0;
  logic [15:0] acc_wdata = '0;
  logic [15:0] acc_rdata;
  logic        dev_req = 1'b0;
  logic [1:0]  dev_cycle = 2'b00;
  logic        dev_in_load = 1'b0;
  logic [15:0] dev_in_data = '0;
  logic [15:0] dev_out_data;
  logic        dma_req;
  logic [1:0]  dma_cycle;
  logic [21:0] dma_addr;
  logic [15:0] dma_wdata;
  logic [15:0] dma_rdata = '0;
  logic        dma_ack = 1'b0, dma_err = 1'b0;
  logic        irq;

  int checks = 0, errors = 0;
  bit done = 0;

  logic [15:0] mem [64];
  logic [21:0] fault_addr = '0;
  logic        fault_en = 1'b0;
  int          ack_cnt = 0;
  logic [21:0] addr_log [8];
  logic [1:0]  cyc_log [8];
  int          req_while_ready = 0;

  always #4 clk = ~clk;

  pdma_regif #(.BASE(BASE)) dut_i (
    .clk(clk), .rst_n(rst_n), .acc_sel(acc_sel), .acc_wr(acc_wr),
    .acc_addr(acc_addr), .acc_wdata(acc_wdata), .acc_rdata(acc_rdata),
    .dev_req(dev_req), .dev_cycle(dev_cycle), .dev_in_load(dev_in_load),
    .dev_in_data(dev_in_data), .dev_out_data(dev_out_data),
    .dma_req(dma_req), .dma_cycle(dma_cycle), .dma_addr(dma_addr),
    .dma_wdata(dma_wdata), .dma_rdata(dma_rdata), .dma_ack(dma_ack),
    .dma_err(dma_err), .irq(irq)
  );

  // memory model: answers one cycle after a request, responses change on negedge
  always @(negedge clk) begin
    if (dma_req && !dma_ack && !dma_err) begin
      if (fault_en && dma_addr == fault_addr) begin
        dma_err <= 1'b1;
      end else begin
        dma_ack   <= 1'b1;
        dma_rdata <= mem[dma_addr[6:1]];
        if (dma_cycle != 2'b00) mem[dma_addr[6:1]] = dma_wdata;
        if (ack_cnt < 8) begin
          addr_log[ack_cnt] = dma_addr;
          cyc_log[ack_cnt]  = dma_cycle;
        end
        ack_cnt++;
      end
    end else begin
      dma_ack <= 1'b0;
      dma_err <= 1'b0;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic [12:0] addr, input logic [15:0] data);
    @(negedge clk);
    acc_sel = 1'b1; acc_wr = 1'b1; acc_addr = addr; acc_wdata = data;
    @(negedge clk);
    acc_sel = 1'b0; acc_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [12:0] addr, output logic [15:0] data);
    @(negedge clk);
    acc_sel = 1'b1; acc_wr = 1'b0; acc_addr = addr;
    #1 data = acc_rdata;
    @(negedge clk);
    acc_sel = 1'b0;
  endtask

  task automatic setup_xfer(input logic [15:0] bar, input logic [15:0] bae, input logic [15:0] wc);
    logic [15:0] d;
    reg_read(BASE + 13'd0, d);   // clears the steering flag
    reg_write(BASE + 13'd2, bar);
    reg_write(BASE + 13'd2, bae);
    reg_write(BASE + 13'd0, wc);
    ack_cnt = 0;
  endtask

  task automatic t_reset;
    logic [15:0] d;
    reg_read(BASE + 13'd4, d);
    check("R12 csr after reset", d, 16'h0080);
    check("R12 irq after reset", irq, 1'b0);
    check("R12 dma_req after reset", dma_req, 1'b0);
    check("R12 out buffer after reset", dev_out_data, 16'h0000);
    reg_read(BASE + 13'd0, d);
    check("R12 count after reset", d, 16'h0000);
  endtask

  task automatic t_decode;
    logic [15:0] d;
    reg_write(BASE + 13'd8, 16'h1234);
    reg_read(BASE + 13'd0, d);
    check("R1 foreign write leaves count", d, 16'h0000);
    reg_write(BASE + 13'd1, 16'h4321);
    reg_read(BASE + 13'd0, d);
    check("R1 odd address write ignored", d, 16'h0000);
    reg_read(BASE - 13'd8, d);
    check("R1 foreign read returns zero", d, 16'h0000);
    reg_write(BASE + 13'd0, 16'h00AA);
    reg_read(BASE + 13'd0, d);
    check("R1 count at offset 0", d, 16'h00AA);
  endtask

  task automatic t_redirect;
    logic [15:0] d;
    reg_write(BASE + 13'd2, 16'h1234);
    reg_write(BASE + 13'd2, 16'hFFFF);
    reg_read(BASE + 13'd2, d);
    check("R2 first access hits address", d, 16'h1234);
    reg_read(BASE + 13'd2, d);
    check("R2 second access hits extension, upper bits zero", d, 16'h003F);
    reg_read(BASE + 13'd2, d);
    reg_read(BASE + 13'd4, d);
    reg_read(BASE + 13'd2, d);
    check("R3 other access drops flag", d, 16'h1234);
    reg_read(BASE + 13'd6, d);
    reg_read(BASE + 13'd2, d);
    check("R3 buffer access drops flag", d, 16'h1234);
  endtask

  task automatic t_buffers;
    logic [15:0] d;
    @(negedge clk); dev_in_load = 1'b1; dev_in_data = 16'hA5C3;
    @(negedge clk); dev_in_load = 1'b0;
    reg_read(BASE + 13'd6, d);
    check("R4 read input buffer", d, 16'hA5C3);
    reg_write(BASE + 13'd6, 16'h5A3C);
    check("R4 write output buffer", dev_out_data, 16'h5A3C);
    reg_read(BASE + 13'd6, d);
    check("R4 input buffer untouched by write", d, 16'hA5C3);
  endtask

  task automatic t_csr;
    logic [15:0] d;
    reg_write(BASE + 13'd4, 16'h8040);
    reg_read(BASE + 13'd4, d);
    check("R5 enable set, error not writable", d, 16'h00C0);
    check("R5 irq with enable and ready", irq, 1'b1);
    reg_write(BASE + 13'd4, 16'h0000);
    check("R5 irq cleared", irq, 1'b0);
  endtask

  task automatic t_read_xfer;
    logic [15:0] d;
    mem[62] = 16'h1111; mem[63] = 16'h2222; mem[0] = 16'h3333;
    setup_xfer(16'hFFFC, 16'h0005, 16'hFFFD);
    dev_cycle = 2'b00;
    reg_write(BASE + 13'd4, 16'h0001);
    repeat (3) @(negedge clk);
    check("R6 no request before device asks", ack_cnt, 0);
    dev_req = 1'b1;
    repeat (40) @(negedge clk);
    check("R8 exactly three words", ack_cnt, 3);
    check("R7 first address", addr_log[0], 22'h05FFFC);
    check("R7 second address", addr_log[1], 22'h05FFFE);
    check("R7 carry into extension", addr_log[2], 22'h060000);
    check("R6 cycle code read", cyc_log[1], 2'b00);
    check("R8 no request after done", req_while_ready, 0);
    dev_req = 1'b0;
    reg_read(BASE + 13'd4, d);
    check("R8 ready after count zero", d, 16'h0080);
    reg_read(BASE + 13'd0, d);
    check("R7 count at zero", d, 16'h0000);
    reg_read(BASE + 13'd2, d);
    check("R7 final low address", d, 16'h0002);
    reg_read(BASE + 13'd2, d);
    check("R7 final extension", d, 16'h0006);
    check("R11 last read word in output buffer", dev_out_data, 16'h3333);
  endtask

  task automatic t_write_xfer;
    @(negedge clk); dev_in_load = 1'b1; dev_in_data = 16'hBEEF;
    @(negedge clk); dev_in_load = 1'b0;
    mem[8] = 16'h0; mem[9] = 16'h0; mem[10] = 16'h0;
    setup_xfer(16'h0010, 16'h0000, 16'hFFFE);
    dev_cycle = 2'b01;
    reg_write(BASE + 13'd4, 16'h0001);
    dev_req = 1'b1;
    repeat (30) @(negedge clk);
    dev_req = 1'b0;
    check("R6 cycle code write", cyc_log[0], 2'b01);
    check("R11 first memory word from input buffer", mem[8], 16'hBEEF);
    check("R11 second memory word", mem[9], 16'hBEEF);
    check("R8 stop after two words", mem[10], 16'h0000);
    check("R11 write cycle leaves output buffer", dev_out_data, 16'h3333);
  endtask

  task automatic t_rmw_xfer;
    @(negedge clk); dev_in_load = 1'b1; dev_in_data = 16'h1357;
    @(negedge clk); dev_in_load = 1'b0;
    mem[16] = 16'h7777;
    setup_xfer(16'h0020, 16'h0000, 16'hFFFF);
    dev_cycle = 2'b10;
    reg_write(BASE + 13'd4, 16'h0001);
    dev_req = 1'b1;
    repeat (20) @(negedge clk);
    dev_req = 1'b0;
    check("R6 cycle code rmw", cyc_log[0], 2'b10);
    check("R11 rmw read into output buffer", dev_out_data, 16'h7777);
    check("R11 rmw write from input buffer", mem[16], 16'h1357);
  endtask

  task automatic t_fault;
    logic [15:0] d;
    setup_xfer(16'h0040, 16'h0000, 16'hFFFC);
    fault_addr = 22'h000042; fault_en = 1'b1;
    dev_cycle = 2'b00;
    reg_write(BASE + 13'd4, 16'h0001);
    dev_req = 1'b1;
    repeat (30) @(negedge clk);
    dev_req = 1'b0;
    check("R9 one good word before fault", ack_cnt, 1);
    reg_read(BASE + 13'd4, d);
    check("R9 error and ready set", d, 16'h8080);
    reg_read(BASE + 13'd0, d);
    check("R9 count at failing word", d, 16'hFFFD);
    reg_read(BASE + 13'd2, d);
    check("R9 address at failing word", d, 16'h0042);
    fault_en = 1'b0;
    reg_write(BASE + 13'd4, 16'h0001);
    reg_read(BASE + 13'd4, d);
    check("R6 start clears error and ready", d, 16'h0000);
    dev_req = 1'b1;
    repeat (40) @(negedge clk);
    dev_req = 1'b0;
    check("R9 restart resumes at failing word", addr_log[1], 22'h000042);
    reg_read(BASE + 13'd4, d);
    check("R8 restart completes", d, 16'h0080);
  endtask

  task automatic t_busy_ignore;
    logic [15:0] d;
    setup_xfer(16'h0050, 16'h0000, 16'hFFFF);
    dev_cycle = 2'b00;
    reg_write(BASE + 13'd4, 16'h0001);
    reg_write(BASE + 13'd0, 16'h1234);
    reg_write(BASE + 13'd2, 16'h0999);
    reg_write(BASE + 13'd2, 16'h0011);
    reg_write(BASE + 13'd4, 16'h0001);
    reg_read(BASE + 13'd0, d);
    check("R10 count write ignored while active", d, 16'hFFFF);
    reg_read(BASE + 13'd2, d);
    check("R10 address write ignored while active", d, 16'h0050);
    reg_read(BASE + 13'd2, d);
    check("R10 extension write ignored while active", d, 16'h0000);
    reg_read(BASE + 13'd4, d);
    check("R10 still active", d, 16'h0000);
    dev_req = 1'b1;
    repeat (20) @(negedge clk);
    dev_req = 1'b0;
    check("R10 second start did not extend run", ack_cnt, 1);
    check("R10 address of the single word", addr_log[0], 22'h000050);
  endtask

  always @(negedge clk) begin
    if (rst_n && dma_req && dut_i.acc_sel === 1'b0 && 0) req_while_ready++;
  end

  // counts requests seen after the read run finished (ready observed via CSR is not needed)
  logic watch_idle = 1'b0;
  always @(negedge clk) if (watch_idle && dma_req) req_while_ready++;

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = 16'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_decode();
    t_redirect();
    t_buffers();
    t_csr();
    fork
      t_read_xfer();
      begin
        wait (ack_cnt == 3);
        repeat (4) @(negedge clk);
        watch_idle = 1'b1;
      end
    join
    watch_idle = 1'b0;
    t_write_xfer();
    t_rmw_xfer();
    t_fault();
    t_busy_ignore();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule